// File: doc/BRIEF.md
# FM Tuning Word Generator

This block turns signed audio samples into the 32-bit frequency tuning word that a direct digital synthesizer uses to produce a frequency-modulated carrier. Each accepted sample becomes a signed fractional modulating value. That value is multiplied by an unsigned peak-deviation constant, and the product is added to a center-frequency constant. The result appears on a 32-bit word port together with a one-cycle valid strobe, and it feeds the synthesizer loader directly.

The block has two input modes, chosen per sample. In mono mode it takes a left and a right 16-bit sample, halves each one and adds them, so the sum stays within 16 bits. To make up for the halving, the mono path uses a deviation constant twice as large. In multiplex mode it takes one 32-bit composite sample as it is. The center constant and the two deviation constants live in registers that can be rewritten while samples flow. A constant word is the desired frequency times 2^32 divided by the synthesizer reference clock. The defaults suit a 125 MHz reference: center 0x4710CB29, which is 34.7 MHz, and a 75 kHz peak deviation of 0x00275254 (0x004EA4A8 for the mono path).

Top module: `fmw_tuner`

## Requirements
- R1: While reset is high, and after it, until the first sample comes out: word_valid is 0 and word is 0. Reset loads center 0x4710CB29, mono deviation 0x004EA4A8 and multiplex deviation 0x00275254.
- R2: In mono mode (mode=0) the modulating value is the 16-bit sum of the arithmetically right-shifted left and right samples (the shift drops each LSB), placed in the upper 16 bits of a 32-bit signed fraction.
- R3: The mono sum cannot overflow. Left=right=0x8000 gives the value -1.0, and left=right=0x7FFF gives 0x7FFE in the upper half.
- R4: In multiplex mode (mode=1) the modulating value is the 32-bit signed mpx input, and left and right have no effect.
- R5: word = center + floor(m * dev / 2^31) modulo 2^32. Here m is the signed 32-bit modulating value, and dev is the unsigned deviation constant for that sample's mode, so a full-scale negative sample gives exactly center - dev.
- R6: word_valid is high for one cycle, three rising edges after the edge that samples in_valid high (that edge counts as the first). Samples may arrive on every cycle.
- R7: word keeps its last value while word_valid is low.
- R8: A write with cfg_wr=1 updates the constant chosen by cfg_sel (0 center, 1 mono deviation, 2 multiplex deviation). The new value applies to samples taken on later edges. A sample taken on the same edge as the write uses the old value.
- R9: A write with cfg_sel=3 changes no constant.
- R10: The mode is captured together with each sample, so consecutive samples may use different modes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode | input | 1 | 0 mono, 1 multiplex, sampled with in_valid |
| in_valid | input | 1 | Sample present this cycle |
| left | input | 16 | Left audio sample, signed |
| right | input | 16 | Right audio sample, signed |
| mpx | input | 32 | Composite sample, signed fraction |
| cfg_wr | input | 1 | Constant write strobe |
| cfg_sel | input | 2 | Constant select: 0 center, 1 mono deviation, 2 multiplex deviation, 3 none |
| cfg_data | input | 32 | Value to write |
| word_valid | output | 1 | Tuning word strobe |
| word | output | 32 | Frequency tuning word |

## Verification
A constant write and a sample capture can fall on the same clock edge, and the new constant must not leak into that sample. The bench provokes this by driving a center write and a sample in one cycle, then a second sample in the next cycle. It expects the first word to use the old center and the second to use the new one. Mode changes between back-to-back samples are checked in the same way, each word against a model that captures the mode with its own sample.

// File: rtl/fmw_pkg.sv
package fmw_pkg;

    localparam int AUD_W  = 16;
    localparam int WORD_W = 32;
    localparam int PAD_W  = WORD_W - AUD_W;
    localparam int PROD_W = 2 * WORD_W + 1;
    localparam int FRAC_SH = WORD_W - 1;
    localparam int NUM_CONST = 3;
    localparam int SEL_W = 2;

    localparam logic [WORD_W-1:0] CENTER_DEFAULT   = 32'h4710_CB29;
    localparam logic [WORD_W-1:0] DEV_MONO_DEFAULT = 32'h004E_A4A8;
    localparam logic [WORD_W-1:0] DEV_MPX_DEFAULT  = 32'h0027_5254;

    typedef enum logic {
        MODE_MONO = 1'b0,
        MODE_MPX  = 1'b1
    } mod_mode_e;

    typedef enum logic [SEL_W-1:0] {
        CSEL_CENTER   = 2'd0,
        CSEL_DEV_MONO = 2'd1,
        CSEL_DEV_MPX  = 2'd2,
        CSEL_NONE     = 2'd3
    } cfg_sel_e;

    typedef struct packed {
        logic                     valid;
        logic signed [WORD_W-1:0] modval;
        logic        [WORD_W-1:0] dev;
        logic        [WORD_W-1:0] center;
    } stage_mod_t;

    typedef struct packed {
        logic                     valid;
        logic        [WORD_W-1:0] offset;
        logic        [WORD_W-1:0] center;
    } stage_off_t;

    function automatic logic signed [WORD_W-1:0] mono_mix(
        input logic [AUD_W-1:0] l,
        input logic [AUD_W-1:0] r
    );
        logic signed [AUD_W-1:0] half_sum;
        half_sum = ($signed(l) >>> 1) + ($signed(r) >>> 1);
        return {half_sum, {PAD_W{1'b0}}};
    endfunction

    function automatic logic [WORD_W-1:0] scale_offset(
        input logic signed [WORD_W-1:0] m,
        input logic        [WORD_W-1:0] dev
    );
        logic signed [PROD_W-1:0] prod;
        prod = $signed({1'b0, dev}) * m;
        return WORD_W'(prod >>> FRAC_SH);
    endfunction

endpackage

// File: rtl/fmw_cfg_regs.sv
module fmw_cfg_regs
    import fmw_pkg::*;
#(
    parameter logic [WORD_W-1:0] CENTER_INIT   = CENTER_DEFAULT,
    parameter logic [WORD_W-1:0] DEV_MONO_INIT = DEV_MONO_DEFAULT,
    parameter logic [WORD_W-1:0] DEV_MPX_INIT  = DEV_MPX_DEFAULT
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  logic [SEL_W-1:0]  sel,
    input  logic [WORD_W-1:0] data,
    output logic [WORD_W-1:0] center,
    output logic [WORD_W-1:0] dev_mono,
    output logic [WORD_W-1:0] dev_mpx
);
    localparam logic [NUM_CONST-1:0][WORD_W-1:0] INITS =
        {DEV_MPX_INIT, DEV_MONO_INIT, CENTER_INIT};

    logic [NUM_CONST-1:0][WORD_W-1:0] regs;

    for (genvar i = 0; i < NUM_CONST; i++) begin : g_const
        always_ff @(posedge clk) begin
            if (rst) begin
                regs[i] <= INITS[i];
            end else if (wr && sel == SEL_W'(i)) begin
                regs[i] <= data;
            end
        end
    end

    assign center   = regs[CSEL_CENTER];
    assign dev_mono = regs[CSEL_DEV_MONO];
    assign dev_mpx  = regs[CSEL_DEV_MPX];
endmodule

// File: rtl/fmw_front.sv
module fmw_front
    import fmw_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic              mode,
    input  logic [AUD_W-1:0]  left,
    input  logic [AUD_W-1:0]  right,
    input  logic [WORD_W-1:0] mpx,
    input  logic [WORD_W-1:0] center,
    input  logic [WORD_W-1:0] dev_mono,
    input  logic [WORD_W-1:0] dev_mpx,
    output stage_mod_t        s_out
);
    mod_mode_e  md;
    stage_mod_t nxt;

    always_comb begin
        md = mod_mode_e'(mode);
        nxt.valid  = in_valid;
        nxt.center = center;
        if (md == MODE_MPX) begin
            nxt.modval = $signed(mpx);
            nxt.dev    = dev_mpx;
        end else begin
            nxt.modval = mono_mix(left, right);
            nxt.dev    = dev_mono;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s_out <= '0;
        end else begin
            s_out.valid <= in_valid;
            if (in_valid) begin
                s_out <= nxt;
            end
        end
    end
endmodule

// File: rtl/fmw_scale.sv
module fmw_scale
    import fmw_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  stage_mod_t s_in,
    output stage_off_t s_out
);
    always_ff @(posedge clk) begin
        if (rst) begin
            s_out <= '0;
        end else begin
            s_out.valid <= s_in.valid;
            if (s_in.valid) begin
                s_out.offset <= scale_offset(s_in.modval, s_in.dev);
                s_out.center <= s_in.center;
            end
        end
    end
endmodule

// File: rtl/fmw_sum.sv
module fmw_sum
    import fmw_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  stage_off_t        s_in,
    output logic              word_valid,
    output logic [WORD_W-1:0] word
);
    always_ff @(posedge clk) begin
        if (rst) begin
            word_valid <= 1'b0;
            word       <= '0;
        end else begin
            word_valid <= s_in.valid;
            if (s_in.valid) begin
                word <= s_in.center + s_in.offset;
            end
        end
    end
endmodule

// File: rtl/fmw_tuner.sv
module fmw_tuner
    import fmw_pkg::*;
#(
    parameter logic [WORD_W-1:0] CENTER_INIT   = CENTER_DEFAULT,
    parameter logic [WORD_W-1:0] DEV_MONO_INIT = DEV_MONO_DEFAULT,
    parameter logic [WORD_W-1:0] DEV_MPX_INIT  = DEV_MPX_DEFAULT
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              mode,
    input  logic              in_valid,
    input  logic [AUD_W-1:0]  left,
    input  logic [AUD_W-1:0]  right,
    input  logic [WORD_W-1:0] mpx,
    input  logic              cfg_wr,
    input  logic [SEL_W-1:0]  cfg_sel,
    input  logic [WORD_W-1:0] cfg_data,
    output logic              word_valid,
    output logic [WORD_W-1:0] word
);
    logic [WORD_W-1:0] center, dev_mono, dev_mpx;
    stage_mod_t        s1;
    stage_off_t        s2;

    fmw_cfg_regs #(
        .CENTER_INIT  (CENTER_INIT),
        .DEV_MONO_INIT(DEV_MONO_INIT),
        .DEV_MPX_INIT (DEV_MPX_INIT)
    ) u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr      (cfg_wr),
        .sel     (cfg_sel),
        .data    (cfg_data),
        .center  (center),
        .dev_mono(dev_mono),
        .dev_mpx (dev_mpx)
    );

    fmw_front u_front (
        .clk     (clk),
        .rst     (rst),
        .in_valid(in_valid),
        .mode    (mode),
        .left    (left),
        .right   (right),
        .mpx     (mpx),
        .center  (center),
        .dev_mono(dev_mono),
        .dev_mpx (dev_mpx),
        .s_out   (s1)
    );

    fmw_scale u_scale (
        .clk  (clk),
        .rst  (rst),
        .s_in (s1),
        .s_out(s2)
    );

    fmw_sum u_sum (
        .clk       (clk),
        .rst       (rst),
        .s_in      (s2),
        .word_valid(word_valid),
        .word      (word)
    );
endmodule

// File: rtl/fmw_tuner_chk.sv
module fmw_tuner_chk
    import fmw_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              mode,
    input logic              in_valid,
    input logic [AUD_W-1:0]  left,
    input logic [AUD_W-1:0]  right,
    input logic [WORD_W-1:0] mpx,
    input logic              cfg_wr,
    input logic [SEL_W-1:0]  cfg_sel,
    input logic [WORD_W-1:0] cfg_data,
    input logic              word_valid,
    input logic [WORD_W-1:0] word
);
    logic [1:0]        since_rst;
    logic [WORD_W-1:0] shadow_center;
    logic              zero_in;
    logic              armed;

    always_ff @(posedge clk) begin
        if (rst) begin
            since_rst <= '0;
        end else if (since_rst != 2'd3) begin
            since_rst <= since_rst + 2'd1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            shadow_center <= CENTER_DEFAULT;
        end else if (cfg_wr && cfg_sel == CSEL_CENTER) begin
            shadow_center <= cfg_data;
        end
    end

    assign armed   = (since_rst == 2'd3);
    assign zero_in = in_valid &&
                     (mode ? (mpx == '0) : (left == '0 && right == '0));

    // R1: reset clears the output strobe and word
    p_reset_clear_r1: assert property (@(posedge clk)
        rst |=> (!word_valid && word == '0));

    // R6: output strobe follows the input strobe by three edges
    p_latency_r6: assert property (@(posedge clk) disable iff (rst)
        armed |-> (word_valid == $past(in_valid, 3)));

    // R7: word is held while no strobe is present
    p_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (armed && !word_valid) |-> $stable(word));

    // R5 and R8: a zero sample yields the center captured with it
    p_zero_center_r5: assert property (@(posedge clk) disable iff (rst)
        (armed && $past(zero_in, 3)) |-> (word == $past(shadow_center, 3)));
endmodule

bind fmw_tuner fmw_tuner_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .mode      (mode),
    .in_valid  (in_valid),
    .left      (left),
    .right     (right),
    .mpx       (mpx),
    .cfg_wr    (cfg_wr),
    .cfg_sel   (cfg_sel),
    .cfg_data  (cfg_data),
    .word_valid(word_valid),
    .word      (word)
);

// File: tb/fmw_tuner_test.sv
`timescale 1ns/1ps
module fmw_tuner_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        mode = 1'b0;
    logic        in_valid = 1'b0;
    logic [15:0] left = '0;
    logic [15:0] right = '0;
    logic [31:0] mpx = '0;
    logic        cfg_wr = 1'b0;
    logic [1:0]  cfg_sel = '0;
    logic [31:0] cfg_data = '0;
    logic        word_valid;
    logic [31:0] word;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [31:0] mdl_c  = 32'h4710_CB29;
    logic [31:0] mdl_dm = 32'h004E_A4A8;
    logic [31:0] mdl_dx = 32'h0027_5254;

    always #2.5 clk = ~clk;

    fmw_tuner uut (
        .clk(clk), .rst(rst), .mode(mode), .in_valid(in_valid),
        .left(left), .right(right), .mpx(mpx),
        .cfg_wr(cfg_wr), .cfg_sel(cfg_sel), .cfg_data(cfg_data),
        .word_valid(word_valid), .word(word)
    );

    function automatic logic [31:0] model(bit md, logic [15:0] l, logic [15:0] r,
                                          logic [31:0] x);
        longint m;
        longint p;
        longint dv;
        int     s;
        if (!md) begin
            s  = (int'($signed(l)) >>> 1) + (int'($signed(r)) >>> 1);
            m  = longint'(s) * 65536;
            dv = longint'({32'd0, mdl_dm});
        end else begin
            m  = longint'($signed(x));
            dv = longint'({32'd0, mdl_dx});
        end
        p = m * dv;
        return mdl_c + 32'(p >>> 31);
    endfunction

    task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    // Single sample: latency, value, then hold (R6, R7)
    task automatic run_one(string req, bit md, logic [15:0] l, logic [15:0] r,
                           logic [31:0] x);
        logic [31:0] exp;
        exp = model(md, l, r, x);
        mode = md; left = l; right = r; mpx = x; in_valid = 1'b1;
        @(negedge clk); in_valid = 1'b0;
        @(negedge clk);
        chk("R6 early strobe", {31'd0, word_valid}, 32'd0);
        @(negedge clk);
        chk("R6 strobe", {31'd0, word_valid}, 32'd1);
        chk(req, word, exp);
        @(negedge clk);
        chk("R6 one-cycle strobe", {31'd0, word_valid}, 32'd0);
        chk("R7 hold", word, exp);
    endtask

    task automatic write_cfg(logic [1:0] sel, logic [31:0] d);
        cfg_wr = 1'b1; cfg_sel = sel; cfg_data = d;
        @(negedge clk);
        cfg_wr = 1'b0;
        case (sel)
            2'd0: mdl_c  = d;
            2'd1: mdl_dm = d;
            2'd2: mdl_dx = d;
            default: ;
        endcase
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        chk("R1 valid in reset", {31'd0, word_valid}, 32'd0);
        chk("R1 word in reset", word, 32'd0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 valid after reset", {31'd0, word_valid}, 32'd0);
        chk("R1 word after reset", word, 32'd0);
    endtask

    task automatic t_mono();
        run_one("R1 R5 mono zero gives default center", 0, 16'h0000, 16'h0000, '0);
        run_one("R2 mono LSBs dropped", 0, 16'h0003, 16'hFFFF, '0);
        run_one("R2 R5 mono mixed", 0, 16'h1000, 16'h2000, '0);
        run_one("R2 mono negative", 0, 16'hC000, 16'h0400, '0);
    endtask

    task automatic t_mono_extremes();
        run_one("R3 full negative", 0, 16'h8000, 16'h8000, '0);
        chk("R3 exact negative deviation", word, 32'h4710_CB29 - 32'h004E_A4A8);
        run_one("R3 full positive", 0, 16'h7FFF, 16'h7FFF, '0);
        run_one("R3 opposite extremes", 0, 16'h8000, 16'h7FFF, '0);
    endtask

    task automatic t_mpx();
        run_one("R4 mpx positive full", 1, 16'h7FFF, 16'h1234, 32'h7FFF_FFFF);
        run_one("R4 R5 mpx negative full", 1, 16'h8000, 16'h8000, 32'h8000_0000);
        chk("R5 exact mpx negative deviation", word, 32'h4710_CB29 - 32'h0027_5254);
        run_one("R4 mpx mid", 1, 16'h5555, 16'hAAAA, 32'h1234_5678);
        run_one("R4 mpx zero ignores audio", 1, 16'h7FFF, 16'h7FFF, 32'h0);
    endtask

    task automatic t_stream();
        localparam int N = 6;
        logic [31:0] exp_q[N];
        bit          md_q[N];
        logic [15:0] l_q[N];
        logic [31:0] x_q[N];
        for (int i = 0; i < N; i++) begin
            md_q[i] = i[0];
            l_q[i]  = 16'(16'h1111 * (i + 1));
            x_q[i]  = 32'h9000_0000 + 32'(i) * 32'h0DEA_D000;
            exp_q[i] = model(md_q[i], l_q[i], 16'hF00D, x_q[i]);
        end
        for (int j = 0; j < N + 3; j++) begin
            if (j >= 3) begin
                chk("R6 back-to-back strobe", {31'd0, word_valid}, 32'd1);
                chk("R10 per-sample mode", word, exp_q[j-3]);
            end
            if (j < N) begin
                in_valid = 1'b1; mode = md_q[j]; left = l_q[j];
                right = 16'hF00D; mpx = x_q[j];
            end else begin
                in_valid = 1'b0;
            end
            @(negedge clk);
        end
        chk("R6 stream end", {31'd0, word_valid}, 32'd0);
    endtask

    task automatic t_cfg();
        logic [31:0] exp_old, exp_new;
        // Write center and capture a sample on the same edge
        exp_old = model(0, 16'h0800, 16'h0800, '0);
        cfg_wr = 1'b1; cfg_sel = 2'd0; cfg_data = 32'h2000_0000;
        in_valid = 1'b1; mode = 1'b0; left = 16'h0800; right = 16'h0800;
        @(negedge clk);
        cfg_wr = 1'b0;
        mdl_c = 32'h2000_0000;
        exp_new = model(0, 16'h0800, 16'h0800, '0);
        @(negedge clk);
        in_valid = 1'b0;
        @(negedge clk);
        chk("R8 same-edge write uses old center", word, exp_old);
        @(negedge clk);
        chk("R8 next sample uses new center", word, exp_new);
        @(negedge clk);
        write_cfg(2'd1, 32'h0100_0000);
        run_one("R8 mono deviation write", 0, 16'h4000, 16'h0000, '0);
        write_cfg(2'd2, 32'h0080_0000);
        run_one("R8 mpx deviation write", 1, '0, '0, 32'hC000_0000);
    endtask

    task automatic t_ignore();
        write_cfg(2'd3, 32'hDEAD_BEEF);
        run_one("R9 select 3 keeps center", 0, 16'h0000, 16'h0000, '0);
        run_one("R9 select 3 keeps mono deviation", 0, 16'h8000, 16'h8000, '0);
        run_one("R9 select 3 keeps mpx deviation", 1, '0, '0, 32'h8000_0000);
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_mono();
        t_mono_extremes();
        t_mpx();
        t_stream();
        t_cfg();
        t_ignore();
        done = 1;
    end

    initial begin
        for (int c = 0; c < 20000 && !done; c++) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule